// File: doc/BRIEF.md
# Thread context CAM matcher

This block decides whether an interrupt notification target belongs to one hardware thread, and through which of the thread's four context rings. A target consists of a format bit, a block number, an index, an ignore flag and a logical server number. The thread holds four context words: physical, pool, OS and user. Each word carries its own valid bit. The physical ring carries no stored identifier. Its identifier is built inside the block from a configured block id and the processor thread id, and a marker bit is placed just above the thread-id field.

A single-cycle start strobe launches the compare. One clock later the block presents a registered result: a match flag, a 2-bit ring code and an unsupported-mode flag. Results hold until the next strobe. Context words arrive already in native bit order.

Top module: `ctx_cam_match`

## Requirements
- R1: The target identifier is `{tgt_blk, tgt_idx}` (block in the upper BLK_W bits, index in the lower IDX_W bits). A stored ring word is `{valid, identifier}`, with the valid bit at the top position and the identifier below it. A ring compares equal only when all identifier bits match.
- R2: The physical identifier is `{cfg_blk_id, idx}`, where `idx` is zero except for two parts. Bit W is set as a marker, and bits W-1..0 hold the low W bits of `thread_id`. W is 8 when `cfg_tid_wide`=1 and 7 when it is 0.
- R3: With format 0 and the ignore flag clear, the block checks the physical ring first, then pool, then OS. The first ring that is both valid and equal to the target is reported.
- R4: The ring codes are physical=3, pool=2, OS=1 and user=0.
- R5: With format 0 and the ignore flag set, the block reports no match with `res_unsup`=1.
- R6: With format 1, the block reports a user-ring match (code 0) only when all four conditions hold: the OS word is valid, the OS identifier equals the target, the user word `{valid, ls}` is valid, and its low LS_W bits equal `tgt_ls`. The ignore flag is not consulted in format 1.
- R7: When nothing matches and the mode is supported, the block reports `res_hit`=0, `res_unsup`=0 and `res_ring`=0.
- R8: `res_valid` is high for exactly the one cycle after a cycle with `start` high. The result outputs change only in that cycle and hold otherwise.
- R9: Under synchronous active-high reset, all outputs are 0.
- R10: A ring whose valid bit is clear never matches, even when its identifier equals the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a compare |
| tgt_fmt | input | 1 | Target format: 0 = specific target, 1 = user level |
| tgt_blk | input | BLK_W | Target block |
| tgt_idx | input | IDX_W | Target index |
| tgt_ignore | input | 1 | Logical-server (ignore) flag |
| tgt_ls | input | LS_W | Requested logical server number |
| cfg_blk_id | input | BLK_W | Block id of this thread's controller |
| cfg_tid_wide | input | 1 | 1 selects an 8-bit thread id, 0 selects 7 bits |
| thread_id | input | TID_W | Processor thread id |
| phys_vld | input | 1 | Physical ring valid |
| pool_word | input | BLK_W+IDX_W+1 | Pool ring {valid, identifier} |
| os_word | input | BLK_W+IDX_W+1 | OS ring {valid, identifier} |
| user_word | input | LS_W+1 | User ring {valid, logical server} |
| res_valid | output | 1 | Result strobe |
| res_hit | output | 1 | A ring matched |
| res_ring | output | 2 | Matched ring code |
| res_unsup | output | 1 | Unsupported logical-server mode |

## Verification
The bench builds the block with its default parameters: a 4-bit block, a 24-bit index, an 8-bit logical server and an 8-bit thread id. With these values both thread-id widths can be exercised through the configuration bit. A narrow-mode thread id with bit 7 set shows that the marker takes that bit's place. Random targets are copied onto several rings at once, so priority collisions occur often, and format 1 cases are generated with each of the four user conditions failing in turn.

// File: rtl/ctx_cam_pkg.sv
package ctx_cam_pkg;
  typedef enum logic [1:0] {
    RING_USER = 2'd0,
    RING_OS   = 2'd1,
    RING_POOL = 2'd2,
    RING_PHYS = 2'd3
  } ring_e;

  typedef struct packed {
    logic  hit;
    logic  unsup;
    ring_e ring;
  } cam_res_t;

  localparam int NUM_CMP = 3; // physical, pool, OS
endpackage

// File: rtl/ctx_cam_physid.sv
module ctx_cam_physid #(
  parameter int BLK_W = 4,
  parameter int IDX_W = 24,
  parameter int TID_W = 8
) (
  input  logic [BLK_W-1:0]       blk_id,
  input  logic                   tid_wide,
  input  logic [TID_W-1:0]       thread_id,
  output logic [BLK_W+IDX_W-1:0] phys_id
);
  localparam int NARROW_W = TID_W - 1;

  logic [IDX_W-1:0] idx;

  always_comb begin
    idx = '0;
    if (tid_wide) begin
      idx[TID_W-1:0] = thread_id;
      idx[TID_W]     = 1'b1;
    end else begin
      idx[NARROW_W-1:0] = thread_id[NARROW_W-1:0];
      idx[NARROW_W]     = 1'b1;
    end
  end

  assign phys_id = {blk_id, idx};
endmodule

// File: rtl/ctx_cam_cmp.sv
module ctx_cam_cmp #(
  parameter int ID_W = 28
) (
  input  logic            vld,
  input  logic [ID_W-1:0] ring_id,
  input  logic [ID_W-1:0] target,
  output logic            hit
);
  assign hit = vld && (ring_id == target);
endmodule

// File: rtl/ctx_cam_sel.sv
module ctx_cam_sel
  import ctx_cam_pkg::*;
#(
  parameter int LS_W = 8
) (
  input  logic               fmt,
  input  logic               ignore,
  input  logic [NUM_CMP-1:0] cmp_hit,   // [0] phys, [1] pool, [2] os
  input  logic [LS_W:0]      user_word,
  input  logic [LS_W-1:0]    want_ls,
  output cam_res_t           res
);
  logic user_ok;
  assign user_ok = user_word[LS_W] && (user_word[LS_W-1:0] == want_ls);

  always_comb begin
    res = '{hit: 1'b0, unsup: 1'b0, ring: RING_USER};
    if (fmt) begin
      if (cmp_hit[2] && user_ok) res = '{hit: 1'b1, unsup: 1'b0, ring: RING_USER};
    end else if (ignore) begin
      res.unsup = 1'b1;
    end else if (cmp_hit[0]) begin
      res = '{hit: 1'b1, unsup: 1'b0, ring: RING_PHYS};
    end else if (cmp_hit[1]) begin
      res = '{hit: 1'b1, unsup: 1'b0, ring: RING_POOL};
    end else if (cmp_hit[2]) begin
      res = '{hit: 1'b1, unsup: 1'b0, ring: RING_OS};
    end
  end
endmodule

// File: rtl/ctx_cam_match.sv
module ctx_cam_match
  import ctx_cam_pkg::*;
#(
  parameter int BLK_W = 4,
  parameter int IDX_W = 24,
  parameter int LS_W  = 8,
  parameter int TID_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   tgt_fmt,
  input  logic [BLK_W-1:0]       tgt_blk,
  input  logic [IDX_W-1:0]       tgt_idx,
  input  logic                   tgt_ignore,
  input  logic [LS_W-1:0]        tgt_ls,
  input  logic [BLK_W-1:0]       cfg_blk_id,
  input  logic                   cfg_tid_wide,
  input  logic [TID_W-1:0]       thread_id,
  input  logic                   phys_vld,
  input  logic [BLK_W+IDX_W:0]   pool_word,
  input  logic [BLK_W+IDX_W:0]   os_word,
  input  logic [LS_W:0]          user_word,
  output logic                   res_valid,
  output logic                   res_hit,
  output logic [1:0]             res_ring,
  output logic                   res_unsup
);
  localparam int ID_W = BLK_W + IDX_W;

  logic [ID_W-1:0]    target;
  logic [ID_W-1:0]    phys_id;
  logic [ID_W-1:0]    ring_id  [NUM_CMP];
  logic [NUM_CMP-1:0] ring_vld;
  logic [NUM_CMP-1:0] cmp_hit;
  cam_res_t           nxt;

  assign target = {tgt_blk, tgt_idx};

  ctx_cam_physid #(.BLK_W(BLK_W), .IDX_W(IDX_W), .TID_W(TID_W)) u_physid (
    .blk_id    (cfg_blk_id),
    .tid_wide  (cfg_tid_wide),
    .thread_id (thread_id),
    .phys_id   (phys_id)
  );

  assign ring_id[0]  = phys_id;
  assign ring_vld[0] = phys_vld;
  assign ring_id[1]  = pool_word[ID_W-1:0];
  assign ring_vld[1] = pool_word[ID_W];
  assign ring_id[2]  = os_word[ID_W-1:0];
  assign ring_vld[2] = os_word[ID_W];

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    ctx_cam_cmp #(.ID_W(ID_W)) u_cmp (
      .vld     (ring_vld[g]),
      .ring_id (ring_id[g]),
      .target  (target),
      .hit     (cmp_hit[g])
    );
  end

  ctx_cam_sel #(.LS_W(LS_W)) u_sel (
    .fmt       (tgt_fmt),
    .ignore    (tgt_ignore),
    .cmp_hit   (cmp_hit),
    .user_word (user_word),
    .want_ls   (tgt_ls),
    .res       (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_ring  <= 2'd0;
      res_unsup <= 1'b0;
    end else begin
      res_valid <= start;
      if (start) begin
        res_hit   <= nxt.hit;
        res_ring  <= nxt.ring;
        res_unsup <= nxt.unsup;
      end
    end
  end
endmodule

// File: rtl/ctx_cam_match_chk.sv
module ctx_cam_match_chk #(
  parameter int BLK_W = 4,
  parameter int IDX_W = 24,
  parameter int LS_W  = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 start,
  input logic                 tgt_fmt,
  input logic                 tgt_ignore,
  input logic [BLK_W-1:0]     tgt_blk,
  input logic [IDX_W-1:0]     tgt_idx,
  input logic                 phys_vld,
  input logic [BLK_W+IDX_W:0] pool_word,
  input logic [BLK_W+IDX_W:0] os_word,
  input logic [LS_W:0]        user_word,
  input logic                 res_valid,
  input logic                 res_hit,
  input logic [1:0]           res_ring,
  input logic                 res_unsup
);
  localparam int ID_W = BLK_W + IDX_W;

  p_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    start |=> res_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !start |=> !res_valid && $stable(res_hit) && $stable(res_ring) && $stable(res_unsup));

  p_unsup_r5: assert property (@(posedge clk) disable iff (rst)
    start && !tgt_fmt && tgt_ignore |=> res_unsup && !res_hit);

  p_user_vld_r6: assert property (@(posedge clk) disable iff (rst)
    start && tgt_fmt && !user_word[LS_W] |=> !res_hit && !res_unsup);

  p_fmt1_code_r4: assert property (@(posedge clk) disable iff (rst)
    start && tgt_fmt |=> res_ring == 2'd0);

  p_invalid_r10: assert property (@(posedge clk) disable iff (rst)
    start && !tgt_fmt && !tgt_ignore && !phys_vld && !pool_word[ID_W] && !os_word[ID_W]
    |=> !res_hit && !res_unsup);

  p_os_only_r3: assert property (@(posedge clk) disable iff (rst)
    start && !tgt_fmt && !tgt_ignore && !phys_vld && !pool_word[ID_W] && os_word[ID_W]
    && os_word[ID_W-1:0] == {tgt_blk, tgt_idx} |=> res_hit && res_ring == 2'd1);

  p_miss_code_r7: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_hit |-> res_ring == 2'd0);
endmodule

bind ctx_cam_match ctx_cam_match_chk #(.BLK_W(BLK_W), .IDX_W(IDX_W), .LS_W(LS_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .tgt_fmt(tgt_fmt), .tgt_ignore(tgt_ignore),
  .tgt_blk(tgt_blk), .tgt_idx(tgt_idx), .phys_vld(phys_vld), .pool_word(pool_word),
  .os_word(os_word), .user_word(user_word), .res_valid(res_valid), .res_hit(res_hit),
  .res_ring(res_ring), .res_unsup(res_unsup)
);

// File: tb/ctx_cam_match_tb.sv
module ctx_cam_match_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BLK_W = 4;
  localparam int IDX_W = 24;
  localparam int LS_W  = 8;
  localparam int TID_W = 8;
  localparam int ID_W  = BLK_W + IDX_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic tgt_fmt = 1'b0, tgt_ignore = 1'b0, cfg_tid_wide = 1'b0, phys_vld = 1'b0;
  logic [BLK_W-1:0] tgt_blk = '0, cfg_blk_id = '0;
  logic [IDX_W-1:0] tgt_idx = '0;
  logic [LS_W-1:0]  tgt_ls = '0;
  logic [TID_W-1:0] thread_id = '0;
  logic [ID_W:0]    pool_word = '0, os_word = '0;
  logic [LS_W:0]    user_word = '0;
  logic res_valid, res_hit, res_unsup;
  logic [1:0] res_ring;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctx_cam_match #(.BLK_W(BLK_W), .IDX_W(IDX_W), .LS_W(LS_W), .TID_W(TID_W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .tgt_fmt(tgt_fmt), .tgt_blk(tgt_blk),
    .tgt_idx(tgt_idx), .tgt_ignore(tgt_ignore), .tgt_ls(tgt_ls), .cfg_blk_id(cfg_blk_id),
    .cfg_tid_wide(cfg_tid_wide), .thread_id(thread_id), .phys_vld(phys_vld),
    .pool_word(pool_word), .os_word(os_word), .user_word(user_word),
    .res_valid(res_valid), .res_hit(res_hit), .res_ring(res_ring), .res_unsup(res_unsup)
  );

  function automatic logic [ID_W-1:0] bench_phys_id();
    logic [IDX_W-1:0] ix;
    if (cfg_tid_wide) ix = 24'h000100 | IDX_W'(thread_id);
    else              ix = 24'h000080 | IDX_W'(thread_id & 8'h7f);
    return {cfg_blk_id, ix};
  endfunction

  // expected {valid, hit, unsup, ring}
  function automatic logic [4:0] model();
    logic [ID_W-1:0] t;
    logic os_eq;
    t = {tgt_blk, tgt_idx};
    os_eq = os_word[ID_W] && os_word[ID_W-1:0] == t;
    if (tgt_fmt) begin
      if (os_eq && user_word[LS_W] && user_word[LS_W-1:0] == tgt_ls) return 5'b1_1_0_00;
      return 5'b1_0_0_00;
    end
    if (tgt_ignore) return 5'b1_0_1_00;
    if (phys_vld && bench_phys_id() == t) return 5'b1_1_0_11;
    if (pool_word[ID_W] && pool_word[ID_W-1:0] == t) return 5'b1_1_0_10;
    if (os_eq) return 5'b1_1_0_01;
    return 5'b1_0_0_00;
  endfunction

  task automatic check(string req, logic [4:0] exp);
    logic [4:0] act;
    act = {res_valid, res_hit, res_unsup, res_ring};
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual {vld,hit,unsup,ring}=%b expected %b", req, act, exp);
    end
  endtask

  // inputs already set; strobe at negedge, check at next negedge
  task automatic launch(string req);
    logic [4:0] exp;
    exp = model();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(req, exp);
  endtask

  task automatic clear_ctx();
    tgt_fmt = 0; tgt_ignore = 0; phys_vld = 0;
    pool_word = '0; os_word = '0; user_word = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    int seed;
    logic [4:0] held;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    check("R9 reset", 5'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R9 after reset", 5'b0);

    // R2 wide thread id
    clear_ctx();
    cfg_blk_id = 4'h5; thread_id = 8'hA7; cfg_tid_wide = 1;
    phys_vld = 1; {tgt_blk, tgt_idx} = {4'h5, 24'h0001A7};
    launch("R2 wide phys");
    // R2 narrow: bit7 of thread id replaced by marker
    cfg_tid_wide = 0; {tgt_blk, tgt_idx} = {4'h5, 24'h0000A7};
    launch("R2 narrow phys");
    {tgt_blk, tgt_idx} = {4'h5, 24'h0001A7};
    launch("R2 narrow rejects wide id");

    // R3 priority: all equal -> phys
    pool_word = {1'b1, 4'h5, 24'h0000A7}; os_word = {1'b1, 4'h5, 24'h0000A7};
    {tgt_blk, tgt_idx} = {4'h5, 24'h0000A7};
    launch("R3 phys over pool/os");
    phys_vld = 0;
    launch("R3 pool over os");
    pool_word[ID_W] = 0;
    launch("R3 os last R4 code");
    // R10 invalid rings with equal ids
    os_word[ID_W] = 0;
    launch("R10 invalid equal ids");
    // R7 miss
    os_word = {1'b1, 4'h5, 24'h0000A8};
    launch("R7 miss");
    // R8 hold
    held = {1'b0, res_hit, res_unsup, res_ring};
    os_word[ID_W-1:0] = {4'h5, 24'h0000A7};
    @(negedge clk);
    check("R8 hold without start", held);

    // R5 ignore
    tgt_ignore = 1;
    launch("R5 unsupported");
    // R6 format 1
    tgt_ignore = 0; tgt_fmt = 1; tgt_ls = 8'h3C; user_word = {1'b1, 8'h3C};
    launch("R6 user all four");
    user_word = {1'b1, 8'h3D};
    launch("R6 ls mismatch");
    user_word = {1'b0, 8'h3C};
    launch("R6 user invalid");
    user_word = {1'b1, 8'h3C}; os_word[ID_W] = 0;
    launch("R6 os invalid");
    os_word = {1'b1, 4'h5, 24'h0000AA};
    launch("R6 os id mismatch");
    os_word = {1'b1, 4'h5, 24'h0000A7}; tgt_ignore = 1;
    launch("R6 ignore not consulted");

    // R1 random
    for (int i = 0; i < 400; i++) begin
      cfg_blk_id = BLK_W'($urandom); thread_id = TID_W'($urandom);
      cfg_tid_wide = 1'($urandom); phys_vld = 1'($urandom);
      tgt_fmt = ($urandom % 4) == 0; tgt_ignore = ($urandom % 6) == 0;
      tgt_ls = LS_W'($urandom % 4);
      if ($urandom % 3 == 0) {tgt_blk, tgt_idx} = bench_phys_id();
      else {tgt_blk, tgt_idx} = ID_W'($urandom % 8);
      pool_word = {1'($urandom), ($urandom % 2) ? {tgt_blk, tgt_idx} : ID_W'($urandom % 8)};
      os_word   = {1'($urandom), ($urandom % 2) ? {tgt_blk, tgt_idx} : ID_W'($urandom % 8)};
      user_word = {1'($urandom), LS_W'($urandom % 4)};
      if ($urandom % 2) launch("R1 random");
      else begin
        @(negedge clk);
        launch("R1 random gap");
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule